// File: doc/BRIEF.md
# Variable-Depth CAN Receive FIFO

This block holds received CAN messages in a first-in first-out queue for the controller's host software. The storage is a row of message slots. The first two slots always receive. The programmable slots that follow can each be set to receive or to transmit. The queue uses every slot from slot 0 up to, but not including, the first programmable slot that is set to transmit. If software puts transmit slots at the end of the row, the queue keeps as much depth as possible.

The upstream filter presents each accepted message with a one-cycle strobe and its payload. The block writes the message into the next free slot and sets that slot's full flag. Software reads the slot that the read pointer names and then frees it with a clear strobe. The clear drops that slot's full flag and moves the read pointer forward. An interrupt code shows that a message is waiting. A watermark interrupt warns when the queue is close to full. A sticky flag records messages that were lost because the queue was full. The slot configuration is captured only at reset or at a flush.

Top module: `can_rxq_fifo`

## Requirements
- R1: Reset (synchronous, rst_ni low) or flush_i clears every full flag, puts both the read and write pointers at slot 0, and clears the overflow flag. The outputs show this from the next clock.
- R2: The queue depth is 2 + i, where i is the lowest index for which slot_tx_cfg_i[i] is 1. Bit i configures programmable slot i, which is slot index i+2. If no bit is 1, the depth is 8. For example, 6'b101000 gives depth 5 and 6'b000001 gives depth 2. Full flags above depth-1 never set.
- R3: An accept strobe taken while the queue is not full stores acc_data_i in the slot at the write pointer, sets that slot's bit in full_o, and moves the write pointer forward. full_o bit n is slot n.
- R4: The read and write pointers step from depth-1 back to 0. rd_ptr_o always stays below the depth.
- R5: clr_full_i while the slot at rd_ptr_o is full clears that flag and moves rd_ptr_o forward one slot. While that slot is empty, clr_full_i has no effect. An accept and a clear in the same cycle both take effect.
- R6: rd_data_o shows the payload of the oldest unread message, which is the one in the slot at rd_ptr_o.
- R7: irq_code_o is 5'b10000 while the slot at rd_ptr_o is full. It is 5'b00000 when that slot is empty, which means the queue is empty.
- R8: wm_irq_o is high when the queue holds at least one message and the number of free slots (depth minus stored count) is at most 1 for wm_sel_i=0, or at most 4 for wm_sel_i=1.
- R9: An accept that arrives while all slots in the depth are full is dropped and sets ovf_o. ovf_o stays high until ovf_clr_i or a flush. A drop in the same cycle as ovf_clr_i leaves the flag set.
- R10: A change on slot_tx_cfg_i with no flush or reset leaves the depth, the pointers and the stored messages unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Empty the queue and capture the slot configuration |
| acc_valid_i | input | 1 | Accepted message strobe |
| acc_data_i | input | DATA_W | Accepted message payload |
| slot_tx_cfg_i | input | PROG_SLOTS | Transmit (1) / receive (0) setting for each programmable slot |
| clr_full_i | input | 1 | Software frees the slot at the read pointer |
| wm_sel_i | input | 1 | Watermark level: 0 = one free slot, 1 = four free slots |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| rd_ptr_o | output | PTR_W | Slot holding the oldest unread message |
| full_o | output | FIX_SLOTS+PROG_SLOTS | Full flag of each slot |
| rd_data_o | output | DATA_W | Payload of the slot at the read pointer |
| irq_code_o | output | 5 | Interrupt code, 5'b10000 when a message is pending |
| wm_irq_o | output | 1 | Watermark warning |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench steps the pointers through several full turns at each depth so that a wrap point set one slot early or late shows up. A design with that error would leave a slot that is never used, or would write above the configured depth. A configuration that changes with no flush must leave the depth as it was. A design that decoded the configuration live would drop messages early. A flush with two transmit bits set must use the lower one. Accepting one message beyond the depth must set the overflow flag, and an accept with a clear on a full queue must be dropped, not squeezed in. A clear on an empty queue must not move the read pointer. The watermark is checked at both levels, including depth 2, where the four-free level covers every non-empty state.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;

   typedef enum logic {
      WM_ONE_FREE  = 1'b0,
      WM_FOUR_FREE = 1'b1
   } wm_sel_e;

   localparam logic [4:0] IRQ_CODE_FIFO = 5'b10000;
   localparam logic [4:0] IRQ_CODE_NONE = 5'b00000;

endpackage

// File: rtl/rxq_depth_calc.sv
// Turns the transmit/receive setting of the programmable slots into a queue depth:
// the fixed slots plus the index of the lowest slot set to transmit.
module rxq_depth_calc #(
   parameter int unsigned FIX_SLOTS  = 2,
   parameter int unsigned PROG_SLOTS = 6,
   parameter int unsigned PTR_W      = 4
) (
   input  logic [PROG_SLOTS-1:0] tx_cfg_i,
   output logic [PTR_W-1:0]      depth_o
);

   logic [PTR_W-1:0] cand [PROG_SLOTS+1];

   assign cand[PROG_SLOTS] = PTR_W'(FIX_SLOTS + PROG_SLOTS);

   for (genvar i = PROG_SLOTS - 1; i >= 0; i--) begin : g_prio
      assign cand[i] = tx_cfg_i[i] ? PTR_W'(FIX_SLOTS + i) : cand[i+1];
   end

   assign depth_o = cand[0];

endmodule

// File: rtl/rxq_ptr.sv
// Pointer that wraps at a depth chosen at run time.
module rxq_ptr #(
   parameter int unsigned PTR_W = 4
) (
   input  logic             clk_i,
   input  logic             clear_i,
   input  logic             adv_i,
   input  logic [PTR_W-1:0] depth_i,
   output logic [PTR_W-1:0] ptr_o
);

   logic [PTR_W-1:0] ptr_q;
   logic             at_last;

   assign at_last = (ptr_q == depth_i - PTR_W'(1));

   always_ff @(posedge clk_i) begin
      if (clear_i) begin
         ptr_q <= '0;
      end else if (adv_i) begin
         ptr_q <= at_last ? '0 : ptr_q + PTR_W'(1);
      end
   end

   assign ptr_o = ptr_q;

endmodule

// File: rtl/rxq_store.sv
// Slot payload registers with one full flag per slot.
module rxq_store #(
   parameter int unsigned SLOTS         = 8,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned PTR_W         = 4,
   parameter bit          RESET_PAYLOAD = 1'b1
) (
   input  logic              clk_i,
   input  logic              clear_all_i,
   input  logic              set_en_i,
   input  logic [PTR_W-1:0]  set_idx_i,
   input  logic [DATA_W-1:0] set_data_i,
   input  logic              clr_en_i,
   input  logic [PTR_W-1:0]  clr_idx_i,
   input  logic [PTR_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [SLOTS-1:0]  full_o
);

   logic [DATA_W-1:0] pay_q [SLOTS];
   logic [SLOTS-1:0]  flag_q;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      localparam logic [PTR_W-1:0] IDX = PTR_W'(i);
      logic hit_set;
      logic hit_clr;

      assign hit_set = set_en_i && (set_idx_i == IDX);
      assign hit_clr = clr_en_i && (clr_idx_i == IDX);

      always_ff @(posedge clk_i) begin
         if (clear_all_i) begin
            flag_q[i] <= 1'b0;
         end else if (hit_set) begin
            flag_q[i] <= 1'b1;
         end else if (hit_clr) begin
            flag_q[i] <= 1'b0;
         end
      end

      if (RESET_PAYLOAD) begin : g_rst_pay
         always_ff @(posedge clk_i) begin
            if (clear_all_i) begin
               pay_q[i] <= '0;
            end else if (hit_set) begin
               pay_q[i] <= set_data_i;
            end
         end
      end else begin : g_free_pay
         always_ff @(posedge clk_i) begin
            if (hit_set) begin
               pay_q[i] <= set_data_i;
            end
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      for (int unsigned k = 0; k < SLOTS; k++) begin
         if (rd_idx_i == PTR_W'(k)) begin
            rd_data_o = pay_q[k];
         end
      end
   end

   assign full_o = flag_q;

endmodule

// File: rtl/can_rxq_fifo.sv
module can_rxq_fifo
   import can_rxq_pkg::*;
#(
   parameter int unsigned FIX_SLOTS     = 2,
   parameter int unsigned PROG_SLOTS    = 6,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned PTR_W         = 4,
   parameter int unsigned WM_NEAR       = 1,
   parameter int unsigned WM_FAR        = 4,
   parameter bit          RESET_PAYLOAD = 1'b1
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            flush_i,
   input  logic                            acc_valid_i,
   input  logic [DATA_W-1:0]               acc_data_i,
   input  logic [PROG_SLOTS-1:0]           slot_tx_cfg_i,
   input  logic                            clr_full_i,
   input  logic                            wm_sel_i,
   input  logic                            ovf_clr_i,
   output logic [PTR_W-1:0]                rd_ptr_o,
   output logic [FIX_SLOTS+PROG_SLOTS-1:0] full_o,
   output logic [DATA_W-1:0]               rd_data_o,
   output logic [4:0]                      irq_code_o,
   output logic                            wm_irq_o,
   output logic                            ovf_o
);

   localparam int unsigned SLOTS = FIX_SLOTS + PROG_SLOTS;

   if (FIX_SLOTS < 1) begin : g_chk_fix
      $error("can_rxq_fifo: at least one fixed receive slot is needed");
   end
   if (PROG_SLOTS < 1) begin : g_chk_prog
      $error("can_rxq_fifo: at least one programmable slot is needed");
   end
   if (SLOTS >= (1 << PTR_W)) begin : g_chk_ptr
      $error("can_rxq_fifo: PTR_W too narrow for the slot count");
   end
   if (WM_NEAR > WM_FAR || WM_FAR >= SLOTS) begin : g_chk_wm
      $error("can_rxq_fifo: watermark levels out of order or range");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("can_rxq_fifo: payload width must be positive");
   end

   logic             reload;
   logic [PTR_W-1:0] depth_new;
   logic [PTR_W-1:0] depth_q;
   logic [PTR_W-1:0] count_q;
   logic [PTR_W-1:0] wr_q;
   logic [PTR_W-1:0] rd_q;
   logic [SLOTS-1:0] full_q;
   logic             ovf_q;
   logic             q_full;
   logic             rd_slot_full;
   logic             push;
   logic             pop;
   logic             drop;
   logic [PTR_W-1:0] free_slots;
   logic [PTR_W-1:0] wm_level;
   wm_sel_e          wm_sel;

   assign reload = !rst_ni || flush_i;

   rxq_depth_calc #(
      .FIX_SLOTS (FIX_SLOTS),
      .PROG_SLOTS(PROG_SLOTS),
      .PTR_W     (PTR_W)
   ) depth_i (
      .tx_cfg_i(slot_tx_cfg_i),
      .depth_o (depth_new)
   );

   always_ff @(posedge clk_i) begin
      if (reload) begin
         depth_q <= depth_new;
      end
   end

   assign q_full = (count_q == depth_q);

   always_comb begin
      rd_slot_full = 1'b0;
      for (int unsigned k = 0; k < SLOTS; k++) begin
         if (rd_q == PTR_W'(k)) begin
            rd_slot_full = full_q[k];
         end
      end
   end

   assign push = acc_valid_i && !q_full && !flush_i;
   assign drop = acc_valid_i && q_full && !flush_i;
   assign pop  = clr_full_i && rd_slot_full && !flush_i;

   always_ff @(posedge clk_i) begin
      if (reload) begin
         count_q <= '0;
      end else if (push && !pop) begin
         count_q <= count_q + PTR_W'(1);
      end else if (pop && !push) begin
         count_q <= count_q - PTR_W'(1);
      end
   end

   always_ff @(posedge clk_i) begin
      if (reload) begin
         ovf_q <= 1'b0;
      end else if (drop) begin
         ovf_q <= 1'b1;
      end else if (ovf_clr_i) begin
         ovf_q <= 1'b0;
      end
   end

   rxq_ptr #(.PTR_W(PTR_W)) wr_ptr_i (
      .clk_i  (clk_i),
      .clear_i(reload),
      .adv_i  (push),
      .depth_i(depth_q),
      .ptr_o  (wr_q)
   );

   rxq_ptr #(.PTR_W(PTR_W)) rd_ptr_i (
      .clk_i  (clk_i),
      .clear_i(reload),
      .adv_i  (pop),
      .depth_i(depth_q),
      .ptr_o  (rd_q)
   );

   rxq_store #(
      .SLOTS        (SLOTS),
      .DATA_W       (DATA_W),
      .PTR_W        (PTR_W),
      .RESET_PAYLOAD(RESET_PAYLOAD)
   ) store_i (
      .clk_i      (clk_i),
      .clear_all_i(reload),
      .set_en_i   (push),
      .set_idx_i  (wr_q),
      .set_data_i (acc_data_i),
      .clr_en_i   (pop),
      .clr_idx_i  (rd_q),
      .rd_idx_i   (rd_q),
      .rd_data_o  (rd_data_o),
      .full_o     (full_q)
   );

   assign wm_sel     = wm_sel_e'(wm_sel_i);
   assign wm_level   = (wm_sel == WM_FOUR_FREE) ? PTR_W'(WM_FAR) : PTR_W'(WM_NEAR);
   assign free_slots = depth_q - count_q;

   assign rd_ptr_o   = rd_q;
   assign full_o     = full_q;
   assign irq_code_o = rd_slot_full ? IRQ_CODE_FIFO : IRQ_CODE_NONE;
   assign wm_irq_o   = (count_q != '0) && (free_slots <= wm_level);
   assign ovf_o      = ovf_q;

endmodule

// File: rtl/can_rxq_fifo_chk.sv
module can_rxq_fifo_chk #(
   parameter int unsigned SLOTS = 8,
   parameter int unsigned PTR_W = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             flush_i,
   input logic             acc_valid_i,
   input logic             clr_full_i,
   input logic             ovf_clr_i,
   input logic [PTR_W-1:0] rd_ptr_o,
   input logic [SLOTS-1:0] full_o,
   input logic [4:0]       irq_code_o,
   input logic             ovf_o,
   input logic [PTR_W-1:0] depth_q,
   input logic [PTR_W-1:0] count_q,
   input logic [PTR_W-1:0] wr_q
);

   logic rd_full;
   assign rd_full = |(full_o & (SLOTS'(1) << rd_ptr_o));

   AST_RD_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_ptr_o < depth_q); // R4
   AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_q < depth_q); // R4
   AST_FULL_WITHIN_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_o >> depth_q) == '0); // R2
   AST_COUNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(full_o) == int'(count_q)); // R3
   AST_CODE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_code_o == 5'b10000) == rd_full); // R7
   AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (full_o == '0) && (rd_ptr_o == '0) && !ovf_o); // R1
   AST_DROP_SETS_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && count_q == depth_q && !flush_i) |=> ovf_o); // R9
   AST_OVF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_clr_i && !acc_valid_i) |=> !ovf_o); // R9
   AST_CLR_EMPTY_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_full_i && !rd_full && !flush_i) |=> $stable(rd_ptr_o)); // R5

endmodule

bind can_rxq_fifo can_rxq_fifo_chk #(
   .SLOTS(FIX_SLOTS + PROG_SLOTS),
   .PTR_W(PTR_W)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .flush_i    (flush_i),
   .acc_valid_i(acc_valid_i),
   .clr_full_i (clr_full_i),
   .ovf_clr_i  (ovf_clr_i),
   .rd_ptr_o   (rd_ptr_o),
   .full_o     (full_o),
   .irq_code_o (irq_code_o),
   .ovf_o      (ovf_o),
   .depth_q    (depth_q),
   .count_q    (count_q),
   .wr_q       (wr_q)
);

// File: tb/can_rxq_fifo_tb_top.sv
module can_rxq_fifo_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int PROG       = 6;
   localparam int SLOTS      = 8;
   localparam int DW         = 32;

   logic            clk_i = 1'b0;
   logic            rst_ni = 1'b0;
   logic            flush_i = 1'b0;
   logic            acc_valid_i = 1'b0;
   logic [DW-1:0]   acc_data_i = '0;
   logic [PROG-1:0] slot_tx_cfg_i = '0;
   logic            clr_full_i = 1'b0;
   logic            wm_sel_i = 1'b0;
   logic            ovf_clr_i = 1'b0;
   logic [3:0]      rd_ptr_o;
   logic [SLOTS-1:0] full_o;
   logic [DW-1:0]   rd_data_o;
   logic [4:0]      irq_code_o;
   logic            wm_irq_o;
   logic            ovf_o;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   can_rxq_fifo dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
      .acc_valid_i(acc_valid_i), .acc_data_i(acc_data_i),
      .slot_tx_cfg_i(slot_tx_cfg_i), .clr_full_i(clr_full_i),
      .wm_sel_i(wm_sel_i), .ovf_clr_i(ovf_clr_i),
      .rd_ptr_o(rd_ptr_o), .full_o(full_o), .rd_data_o(rd_data_o),
      .irq_code_o(irq_code_o), .wm_irq_o(wm_irq_o), .ovf_o(ovf_o)
   );

   // behavioural reference
   logic [DW-1:0] mq[$];
   int m_depth = 8;
   int m_rd = 0;
   bit m_ovf = 1'b0;
   int total = 0;
   int bad = 0;
   int seq = 1;

   function automatic int calc_depth(logic [PROG-1:0] c);
      for (int i = 0; i < PROG; i++) if (c[i]) return 2 + i;
      return 2 + PROG;
   endfunction

   task automatic check(bit ok, string tag, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic [SLOTS-1:0] ef;
      int free;
      bit ewm;
      ef = '0;
      for (int i = 0; i < m_depth; i++)
         if (((i - m_rd + m_depth) % m_depth) < mq.size()) ef[i] = 1'b1;
      free = m_depth - mq.size();
      ewm = (mq.size() > 0) && (free <= (wm_sel_i ? 4 : 1));
      check(int'(rd_ptr_o) == m_rd, "R4", "rd_ptr", rd_ptr_o, m_rd);
      check(full_o == ef, "R3", "full", full_o, ef);
      check(irq_code_o == (mq.size() > 0 ? 5'b10000 : 5'b00000), "R7", "irq_code",
            irq_code_o, (mq.size() > 0 ? 5'b10000 : 5'b00000));
      check(wm_irq_o == ewm, "R8", "wm_irq", wm_irq_o, ewm);
      check(ovf_o == m_ovf, "R9", "ovf", ovf_o, m_ovf);
      if (mq.size() > 0) check(rd_data_o == mq[0], "R6", "rd_data", rd_data_o, mq[0]);
   endtask

   task automatic step(bit acc, bit clr, bit oclr);
      int pre;
      logic [DW-1:0] d;
      d = 32'hA500_0000 + seq;
      seq++;
      acc_valid_i = acc; acc_data_i = d; clr_full_i = clr; ovf_clr_i = oclr;
      @(posedge clk_i);
      pre = mq.size();
      if (clr && pre > 0) begin
         void'(mq.pop_front());
         m_rd = (m_rd + 1) % m_depth;
      end
      if (oclr) m_ovf = 1'b0;
      if (acc) begin
         if (pre == m_depth) m_ovf = 1'b1;
         else mq.push_back(d);
      end
      @(negedge clk_i);
      acc_valid_i = 1'b0; clr_full_i = 1'b0; ovf_clr_i = 1'b0;
      compare();
   endtask

   task automatic do_flush(logic [PROG-1:0] cfg);
      slot_tx_cfg_i = cfg;
      flush_i = 1'b1;
      @(posedge clk_i);
      mq.delete(); m_rd = 0; m_ovf = 1'b0; m_depth = calc_depth(cfg);
      @(negedge clk_i);
      flush_i = 1'b0;
      compare();
      check(full_o == '0 && rd_ptr_o == 0 && !ovf_o, "R1", "flush state",
            {full_o, rd_ptr_o}, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk_i);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      slot_tx_cfg_i = '0;
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      rst_ni = 1'b1;
      m_depth = calc_depth(slot_tx_cfg_i);
      compare();
      check(full_o == '0 && rd_ptr_o == 0 && !ovf_o && irq_code_o == 0, "R1",
            "reset state", {full_o, rd_ptr_o}, 0);

      // depth 8: fill to the brim, then one more
      wm_sel_i = 1'b0;
      for (int i = 0; i < 8; i++) step(1, 0, 0);
      check(ovf_o == 1'b0 && full_o == 8'hFF, "R2", "eight slots taken", full_o, 8'hFF);
      step(1, 0, 0);
      check(ovf_o == 1'b1, "R9", "drop on full", ovf_o, 1);
      step(1, 1, 0);   // accept+clear while full: accept dropped
      step(0, 0, 1);
      check(ovf_o == 1'b0, "R9", "overflow cleared", ovf_o, 0);
      for (int i = 0; i < 7; i++) step(0, 1, 0);
      check(rd_ptr_o == 0, "R4", "read wrap to 0", rd_ptr_o, 0);
      step(0, 1, 0);
      check(rd_ptr_o == 0 && full_o == 0, "R5", "clear on empty", rd_ptr_o, 0);

      // four-free level
      wm_sel_i = 1'b1;
      for (int i = 0; i < 3; i++) step(1, 0, 0);
      check(wm_irq_o == 1'b0, "R8", "five free", wm_irq_o, 0);
      step(1, 0, 0);
      check(wm_irq_o == 1'b1, "R8", "four free", wm_irq_o, 1);
      for (int i = 0; i < 4; i++) step(0, 1, 0);

      // configuration change without flush
      slot_tx_cfg_i = 6'b001000;
      for (int i = 0; i < 8; i++) step(1, 0, 0);
      check(ovf_o == 1'b0 && full_o == 8'hFF, "R10", "depth kept at 8", full_o, 8'hFF);

      // flush picks the lowest transmit slot
      do_flush(6'b101000);
      for (int i = 0; i < 5; i++) step(1, 0, 0);
      check(full_o == 8'h1F && !ovf_o, "R2", "depth 5 filled", full_o, 8'h1F);
      step(1, 0, 0);
      check(ovf_o == 1'b1, "R2", "depth 5 overflow", ovf_o, 1);
      for (int i = 0; i < 12; i++) step(1, 1, 0);

      do_flush(6'b000001);
      wm_sel_i = 1'b0;
      step(1, 0, 0);
      check(wm_irq_o == 1'b1, "R8", "depth 2 one free", wm_irq_o, 1);
      step(1, 0, 0);
      step(1, 0, 0);
      check(ovf_o == 1'b1 && full_o == 8'h03, "R2", "depth 2", full_o, 8'h03);
      for (int i = 0; i < 6; i++) step(1, 1, 0);

      // random traffic with occasional reconfiguration
      for (int i = 0; i < 600; i++) begin
         if ($urandom_range(0, 60) == 0) do_flush(PROG'($urandom));
         wm_sel_i = 1'($urandom);
         step(($urandom_range(0, 9) < 6), ($urandom_range(0, 9) < 5),
              ($urandom_range(0, 19) == 0));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule